// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a real address by walking a tree of page tables held in memory. A caller gives it the address, the base of the root table, how many index bits the root level uses, and the total address-space size as a power-of-two exponent. The walker then reads one 64-bit table entry per level through a plain request/response read port. It follows directory entries down the tree until it reaches a leaf, or until it finds an invalid entry or a configuration that is not allowed.

At every level, a rule check runs before the read is issued. That check restricts which index widths may appear at which depth. A table base that is not aligned is quietly realigned. The remaining address-space exponent shrinks by the index width of each level, so whatever is left when the leaf is reached is the page-size exponent.

The walk ends with a one-cycle done pulse. With it come a fault code, the real address, the page-size exponent and the raw leaf entry. The block does no permission checking. It does not translate the table addresses themselves.

Top module: `radix_walker`

## Requirements
- R1: After reset, `done` and `mem_req` are low and `fault` reads 0.
- R2: The level rules are checked before each read. Level 0 needs a size exponent of 52 and an index width of 13. Levels 1 and 2 need an index width of 9. Level 3 accepts 9 or 5. Any deeper level always fails. A failed check ends the walk with fault code 2 (bad configuration), and no read is issued for that level.
- R3: The read address at each level is the aligned base plus 8 times the index. The index is the virtual address shifted right by (remaining exponent minus index width), masked to the index width.
- R4: Before a table base is used, its low (index width + 3) bits are cleared. This applies to the root base and to every base taken from an entry.
- R5: An entry with bit 63 (valid) clear ends the walk with fault code 1 (no entry), and `real_addr` reads 0.
- R6: Each valid entry lowers the remaining exponent by that level's index width. On a leaf, `page_exp` reports what is left.
- R7: For a valid entry with bit 62 (leaf) clear, the next index width comes from entry bits 4:0. The next base comes from entry bits 55:8, placed at the same bit positions.
- R8: On a leaf, `real_addr` is built from two parts. Entry bits 55:12 supply the bits at and above `page_exp`. The virtual address supplies the bits below `page_exp`. The fault code is 0.
- R9: `mem_req` is a one-cycle pulse. No new request is made until `mem_rvalid` answers the outstanding one. A `mem_rvalid` arriving while no request is outstanding is ignored.
- R10: `done` is a one-cycle pulse, and the results hold until the next walk ends. `start` has no effect while a walk is in progress.
- R11: On a leaf, `leaf_entry` returns the full 64-bit leaf entry as read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| va | input | 64 | Virtual address to translate |
| root_base | input | 64 | Root table base address |
| root_width | input | 5 | Index width of the root level |
| space_size | input | 7 | Total address-space size exponent |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 64 | Read address (valid with `mem_req`) |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data (table entry) |
| done | output | 1 | Walk finished pulse |
| fault | output | 2 | 0 none, 1 no entry, 2 bad configuration |
| real_addr | output | 64 | Translated real address |
| page_exp | output | 7 | Page-size exponent |
| leaf_entry | output | 64 | Leaf entry that ended the walk |

## Verification
Four-level walks are swept over many virtual addresses and a spread of response latencies. Because the index bits then land in every level's field, a wrong shift or mask shows up in the read addresses. Leaves planted at levels 0, 1, 2 and 3, with both last-level widths, separate page-exponent bookkeeping errors from errors in combining the real address. Invalid entries at each depth, bad widths at each depth, and a directory at the last level each stop the walk at a known read count. Those counts tell the no-entry path from the rule check and show whether the check comes before or after the read. Deliberately misaligned bases, stray read responses, and `start` pulses during a walk test realignment, response filtering and busy-time blocking.

// File: rtl/rw_pkg.sv
`timescale 1ns/1ps
package rw_pkg;
    localparam int WORD_W   = 64;
    localparam int SIZE_W   = 7;
    localparam int WIDTH_W  = 5;
    localparam int LVL_W    = 3;
    localparam int VALID_BIT = 63;
    localparam int LEAF_BIT  = 62;
    localparam int FIELD_HI  = 55;
    localparam int BASE_LO   = 8;
    localparam int PAGE_LO   = 12;

    localparam logic [WORD_W-1:0] FIELD_TOP  = (WORD_W'(1) << (FIELD_HI + 1)) - WORD_W'(1);
    localparam logic [WORD_W-1:0] BASE_FIELD = FIELD_TOP & ~((WORD_W'(1) << BASE_LO) - WORD_W'(1));
    localparam logic [WORD_W-1:0] PAGE_FIELD = FIELD_TOP & ~((WORD_W'(1) << PAGE_LO) - WORD_W'(1));

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_NO_ENTRY = 2'd1,
        FLT_BAD_CFG  = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WAIT
    } walk_state_e;

    typedef struct packed {
        logic               valid;
        logic               leaf;
        logic [WORD_W-1:0]  base;
        logic [WIDTH_W-1:0] width;
    } tbl_entry_t;

    function automatic logic [WORD_W-1:0] low_mask(input logic [SIZE_W-1:0] n);
        if (n >= SIZE_W'(WORD_W))
            return '1;
        return (WORD_W'(1) << n) - WORD_W'(1);
    endfunction

    function automatic tbl_entry_t decode_entry(input logic [WORD_W-1:0] raw);
        tbl_entry_t e;
        e.valid = raw[VALID_BIT];
        e.leaf  = raw[LEAF_BIT];
        e.base  = raw & BASE_FIELD;
        e.width = raw[WIDTH_W-1:0];
        return e;
    endfunction
endpackage

// File: rtl/rw_level_rule.sv
`timescale 1ns/1ps
module rw_level_rule
    import rw_pkg::*;
#(
    parameter int ROOT_SPACE = 52,
    parameter int ROOT_WIDTH = 13,
    parameter int MID_WIDTH  = 9,
    parameter int ALT_WIDTH  = 5,
    parameter int LAST_LEVEL = 3
) (
    input  logic [LVL_W-1:0]   level,
    input  logic [SIZE_W-1:0]  rem,
    input  logic [WIDTH_W-1:0] width,
    output logic               ok
);
    localparam logic [LVL_W-1:0]   LAST_L = LVL_W'(LAST_LEVEL);
    localparam logic [WIDTH_W-1:0] W_ROOT = WIDTH_W'(ROOT_WIDTH);
    localparam logic [WIDTH_W-1:0] W_MID  = WIDTH_W'(MID_WIDTH);
    localparam logic [WIDTH_W-1:0] W_ALT  = WIDTH_W'(ALT_WIDTH);
    localparam logic [SIZE_W-1:0]  S_ROOT = SIZE_W'(ROOT_SPACE);

    always_comb begin
        if (level == '0)
            ok = (rem == S_ROOT) && (width == W_ROOT);
        else if (level < LAST_L)
            ok = (width == W_MID);
        else if (level == LAST_L)
            ok = (width == W_MID) || (width == W_ALT);
        else
            ok = 1'b0;
    end
endmodule

// File: rtl/rw_entry_addr.sv
`timescale 1ns/1ps
module rw_entry_addr
    import rw_pkg::*;
(
    input  logic [WORD_W-1:0]  va,
    input  logic [WORD_W-1:0]  base,
    input  logic [SIZE_W-1:0]  rem,
    input  logic [WIDTH_W-1:0] width,
    output logic [WORD_W-1:0]  addr
);
    logic [SIZE_W-1:0] width_x;
    logic [SIZE_W-1:0] shamt;
    logic [WORD_W-1:0] index;
    logic [WORD_W-1:0] aligned;

    always_comb begin
        width_x = SIZE_W'(width);
        // clamp: an oversize width only appears on a path that faults next
        shamt   = (width_x > rem) ? '0 : (rem - width_x);
        index   = (va >> shamt) & low_mask(width_x);
        aligned = base & ~low_mask(width_x + SIZE_W'(3));
        addr    = aligned + (index << 3);
    end
endmodule

// File: rtl/rw_leaf_compose.sv
`timescale 1ns/1ps
module rw_leaf_compose
    import rw_pkg::*;
(
    input  logic [WORD_W-1:0] va,
    input  logic [WORD_W-1:0] raw,
    input  logic [SIZE_W-1:0] rem,
    output logic [WORD_W-1:0] real_addr
);
    logic [WORD_W-1:0] keep;

    always_comb begin
        keep      = low_mask(rem);
        real_addr = ((raw & PAGE_FIELD) & ~keep) | (va & keep);
    end
endmodule

// File: rtl/radix_walker.sv
`timescale 1ns/1ps
module radix_walker
    import rw_pkg::*;
#(
    parameter int ROOT_SPACE = 52,
    parameter int ROOT_WIDTH = 13,
    parameter int MID_WIDTH  = 9,
    parameter int ALT_WIDTH  = 5,
    parameter int LAST_LEVEL = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [WORD_W-1:0]    va,
    input  logic [WORD_W-1:0]    root_base,
    input  logic [WIDTH_W-1:0]   root_width,
    input  logic [SIZE_W-1:0]    space_size,
    output logic                 mem_req,
    output logic [WORD_W-1:0]    mem_addr,
    input  logic                 mem_rvalid,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 done,
    output logic [1:0]           fault,
    output logic [WORD_W-1:0]    real_addr,
    output logic [SIZE_W-1:0]    page_exp,
    output logic [WORD_W-1:0]    leaf_entry
);
    walk_state_e        state_q;
    logic [LVL_W-1:0]   level_q;
    logic [SIZE_W-1:0]  rem_q;
    logic [WIDTH_W-1:0] width_q;
    logic [WORD_W-1:0]  addr_q;
    logic [WORD_W-1:0]  va_q;

    logic               done_q;
    fault_e             fault_q;
    logic [WORD_W-1:0]  real_q;
    logic [SIZE_W-1:0]  page_q;
    logic [WORD_W-1:0]  leaf_q;

    tbl_entry_t         ent;
    logic [SIZE_W-1:0]  rem_next;
    logic               lvl_ok;
    logic [WORD_W-1:0]  calc_va, calc_base, calc_addr, leaf_real;
    logic [SIZE_W-1:0]  calc_rem;
    logic [WIDTH_W-1:0] calc_width;

    always_comb begin
        ent      = decode_entry(mem_rdata);
        rem_next = rem_q - SIZE_W'(width_q);
        if (state_q == ST_IDLE) begin
            calc_va    = va;
            calc_base  = root_base;
            calc_rem   = space_size;
            calc_width = root_width;
        end else begin
            calc_va    = va_q;
            calc_base  = ent.base;
            calc_rem   = rem_next;
            calc_width = ent.width;
        end
    end

    rw_level_rule #(
        .ROOT_SPACE (ROOT_SPACE),
        .ROOT_WIDTH (ROOT_WIDTH),
        .MID_WIDTH  (MID_WIDTH),
        .ALT_WIDTH  (ALT_WIDTH),
        .LAST_LEVEL (LAST_LEVEL)
    ) i_rule (
        .level (level_q),
        .rem   (rem_q),
        .width (width_q),
        .ok    (lvl_ok)
    );

    rw_entry_addr i_addr (
        .va    (calc_va),
        .base  (calc_base),
        .rem   (calc_rem),
        .width (calc_width),
        .addr  (calc_addr)
    );

    rw_leaf_compose i_leaf (
        .va        (va_q),
        .raw       (mem_rdata),
        .rem       (rem_next),
        .real_addr (leaf_real)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            level_q <= '0;
            rem_q   <= '0;
            width_q <= '0;
            addr_q  <= '0;
            va_q    <= '0;
            done_q  <= 1'b0;
            fault_q <= FLT_NONE;
            real_q  <= '0;
            page_q  <= '0;
            leaf_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        va_q    <= va;
                        rem_q   <= space_size;
                        width_q <= root_width;
                        addr_q  <= calc_addr;
                        level_q <= '0;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (lvl_ok) begin
                        state_q <= ST_WAIT;
                    end else begin
                        done_q  <= 1'b1;
                        fault_q <= FLT_BAD_CFG;
                        real_q  <= '0;
                        leaf_q  <= '0;
                        page_q  <= rem_q;
                        state_q <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (!ent.valid) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_NO_ENTRY;
                            real_q  <= '0;
                            leaf_q  <= '0;
                            page_q  <= rem_q;
                            state_q <= ST_IDLE;
                        end else if (ent.leaf) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_NONE;
                            real_q  <= leaf_real;
                            leaf_q  <= mem_rdata;
                            page_q  <= rem_next;
                            state_q <= ST_IDLE;
                        end else begin
                            rem_q   <= rem_next;
                            width_q <= ent.width;
                            addr_q  <= calc_addr;
                            level_q <= level_q + LVL_W'(1);
                            state_q <= ST_CHECK;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req    = (state_q == ST_CHECK) && lvl_ok;
    assign mem_addr   = addr_q;
    assign done       = done_q;
    assign fault      = fault_q;
    assign real_addr  = real_q;
    assign page_exp   = page_q;
    assign leaf_entry = leaf_q;

    // R9: a request is never followed by another in the next cycle
    p_req_single_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R9: completion and a new request never coincide
    p_no_req_at_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

    // R3: entry addresses are 8-byte aligned
    p_req_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: a start while busy leaves the captured address alone
    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start) |=> $stable(va_q));

    // R2: a bad-configuration ending is not preceded by a read request
    p_badcfg_no_read_r2: assert property (@(posedge clk) disable iff (rst)
        (done && fault == FLT_BAD_CFG) |-> !$past(mem_req));

    // R2: no read is outstanding beyond the last permitted level
    p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> (level_q <= LVL_W'(LAST_LEVEL)));

    // R8: a successful walk keeps the in-page offset of the address
    p_leaf_offset_r8: assert property (@(posedge clk) disable iff (rst)
        (done && fault == FLT_NONE) |-> (real_addr[PAGE_LO-1:0] == va_q[PAGE_LO-1:0]));
endmodule

// File: tb/test_radix_walker.sv
`timescale 1ns/1ps
module test_radix_walker;
    localparam logic [63:0] VBIT    = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LBIT    = 64'h4000_0000_0000_0000;
    localparam logic [63:0] BASE_F  = 64'h00FF_FFFF_FFFF_FF00;
    localparam logic [63:0] RPN_F   = 64'h00FF_FFFF_FFFF_F000;
    localparam logic [63:0] PAYLOAD = 64'h00AB_CDEF_9876_5A5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] s_va = '0;
    logic [63:0] s_root = '0;
    logic [4:0]  s_width = '0;
    logic [6:0]  s_size = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [1:0]  fault;
    logic [63:0] real_addr;
    logic [6:0]  page_exp;
    logic [63:0] leaf_entry;

    int n_tests = 0;
    int n_fail  = 0;
    bit all_done = 1'b0;

    always #4 clk = ~clk;

    radix_walker i_radix_walker (
        .clk(clk), .rst(rst), .start(start), .va(s_va), .root_base(s_root),
        .root_width(s_width), .space_size(s_size), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .real_addr(real_addr), .page_exp(page_exp),
        .leaf_entry(leaf_entry)
    );

    // scenario description
    logic [63:0] tb_base [7];
    int          tb_w    [7];
    int          stop_lvl;
    int          stop_kind;   // 0 leaf, 1 invalid, 2 directories only
    int          root_size;
    logic [63:0] ent      [7];
    logic [63:0] exp_addr [7];
    int          n_exp;
    int          exp_fault;
    logic [63:0] exp_real, exp_leaf;
    int          exp_page;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit rule_ok(int k, int rem, int w);
        if (k == 0) return (rem == 52) && (w == 13);
        if (k == 1 || k == 2) return w == 9;
        if (k == 3) return (w == 9) || (w == 5);
        return 1'b0;
    endfunction

    function automatic logic [63:0] ea(logic [63:0] base, logic [63:0] va, int rem, int w);
        logic [63:0] idx;
        idx = (va >> (rem - w)) & ((64'd1 << w) - 64'd1);
        return (base & ~((64'd1 << (w + 3)) - 64'd1)) + (idx << 3);
    endfunction

    task automatic setup(input logic [63:0] root, input int size, input int w0,
                         input logic [63:0] b1, input int w1, input logic [63:0] b2, input int w2,
                         input logic [63:0] b3, input int w3, input int stop, input int kind);
        tb_base[0] = root; tb_w[0] = w0;
        tb_base[1] = b1;   tb_w[1] = w1;
        tb_base[2] = b2;   tb_w[2] = w2;
        tb_base[3] = b3;   tb_w[3] = w3;
        tb_base[4] = 64'h0040_0000; tb_w[4] = 9;
        tb_base[5] = 64'h0050_0000; tb_w[5] = 9;
        tb_base[6] = 64'h0060_0000; tb_w[6] = 9;
        root_size = size; stop_lvl = stop; stop_kind = kind;
        for (int k = 0; k < 6; k++) begin
            if (k < stop || kind == 2)
                ent[k] = VBIT | (tb_base[k+1] & BASE_F) | (64'(tb_w[k+1]) & 64'h1F);
            else if (k == stop && kind == 0)
                ent[k] = VBIT | LBIT | PAYLOAD;
            else if (k == stop)
                ent[k] = LBIT | PAYLOAD;
            else
                ent[k] = '0;
        end
    endtask

    task automatic model(input logic [63:0] va);
        int rem;
        logic [63:0] bk, m;
        rem = root_size; n_exp = 0; exp_fault = 0;
        exp_real = '0; exp_leaf = '0; exp_page = 0;
        for (int k = 0; k < 6; k++) begin
            if (!rule_ok(k, rem, tb_w[k])) begin exp_fault = 2; break; end
            bk = (k == 0) ? tb_base[0] : (tb_base[k] & BASE_F);
            exp_addr[k] = ea(bk, va, rem, tb_w[k]);
            n_exp++;
            if (stop_kind == 1 && k == stop_lvl) begin exp_fault = 1; break; end
            rem = rem - tb_w[k];
            if (stop_kind == 0 && k == stop_lvl) begin
                m = (64'd1 << rem) - 64'd1;
                exp_real = (ent[k] & RPN_F & ~m) | (va & m);
                exp_page = rem;
                exp_leaf = ent[k];
                break;
            end
        end
    endtask

    task automatic run_walk(input logic [63:0] va, input int lat, input bit spur,
                            input bit poke, input string tag);
        int reads, cnt, serve;
        bit finished;
        model(va);
        reads = 0; cnt = 0; serve = 0; finished = 1'b0;
        @(negedge clk);
        if (spur) begin mem_rvalid = 1'b1; mem_rdata = ~PAYLOAD; end
        @(negedge clk);
        mem_rvalid = 1'b0;
        s_va = va; s_root = tb_base[0]; s_width = 5'(tb_w[0]); s_size = 7'(root_size);
        start = 1'b1;
        for (int cyc = 0; cyc < 300 && !finished; cyc++) begin
            @(negedge clk);
            start = 1'b0; s_va = va; mem_rvalid = 1'b0;
            if (done) begin
                finished = 1'b1;
            end else begin
                if (cnt > 0) begin
                    cnt--;
                    if (cnt == 0) begin
                        mem_rvalid = 1'b1;
                        mem_rdata  = (serve < 6) ? ent[serve] : 64'h0;
                    end
                end
                if (mem_req) begin
                    if (reads < n_exp)
                        chk({tag, " R3 entry address"}, mem_addr, exp_addr[reads]);
                    serve = reads; reads++; cnt = (lat < 1) ? 1 : lat;
                    if (spur) begin mem_rvalid = 1'b1; mem_rdata = ~ent[(serve < 6) ? serve : 0]; end
                    if (poke) begin start = 1'b1; s_va = ~va; end
                end
            end
        end
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL %s R10 walk never finished actual=busy expected=done", tag);
        end
        chk({tag, " R9 read count"}, 64'(reads), 64'(n_exp));
        chk({tag, " fault code"}, 64'(fault), 64'(exp_fault));
        if (exp_fault == 0) begin
            chk({tag, " R8 real address"}, real_addr, exp_real);
            chk({tag, " R6 page exponent"}, 64'(page_exp), 64'(exp_page));
            chk({tag, " R11 leaf entry"}, leaf_entry, exp_leaf);
        end else begin
            chk({tag, " R5 real address zero on fault"}, real_addr, 64'h0);
        end
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, 64'(done), 64'h0);
    endtask

    initial begin
        #(8 * 150000);
        if (!all_done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (4) @(negedge clk);
        chk("R1 done after reset", 64'(done), 64'h0);
        chk("R1 request after reset", 64'(mem_req), 64'h0);
        chk("R1 fault after reset", 64'(fault), 64'h0);
        rst = 1'b0;
        @(negedge clk);

        // four-level walks, 4 KiB leaves, address sweep (R7 directory fields)
        setup(64'h0001_0000, 52, 13, 64'h0020_0000, 9, 64'h0030_0000, 9, 64'h0038_0000, 9, 3, 0);
        for (int i = 0; i < 12; i++) begin
            v = (64'h0003_A5C3_96E1_7B2D * 64'(i + 1)) & 64'h000F_FFFF_FFFF_FFFF;
            run_walk(v, (i % 3) + 1, 1'b0, 1'b0, "R7 four-level");
        end
        // last level with narrow width (R2)
        setup(64'h0001_0000, 52, 13, 64'h0020_0000, 9, 64'h0030_0000, 9, 64'h0038_0000, 5, 3, 0);
        for (int i = 0; i < 4; i++)
            run_walk(64'h000D_1234_5678_9ABC + 64'(i * 64'h0000_0777_3333_1111), 2, 1'b0, 1'b0, "R2 narrow last");
        // leaves at shallower levels (R6)
        for (int s = 0; s < 3; s++) begin
            setup(64'h0001_0000, 52, 13, 64'h0020_0000, 9, 64'h0030_0000, 9, 64'h0038_0000, 9, s, 0);
            run_walk(64'h000B_EEF0_1357_9BDF, 1, 1'b0, 1'b0, "R6 shallow leaf");
        end
        // invalid entries at every depth (R5)
        for (int s = 0; s < 4; s++) begin
            setup(64'h0001_0000, 52, 13, 64'h0020_0000, 9, 64'h0030_0000, 9, 64'h0038_0000, 9, s, 1);
            run_walk(64'h0002_4680_ACE0_2468, 2, 1'b0, 1'b0, "R5 invalid entry");
        end
        // bad root configuration, no read (R2)
        setup(64'h0001_0000, 48, 13, 64'h0020_0000, 9, 64'h0030_0000, 9, 64'h0038_0000, 9, 3, 0);
        run_walk(64'h0000_1111_2222_3333, 1, 1'b0, 1'b0, "R2 bad root size");
        setup(64'h0001_0000, 52, 12, 64'h0020_0000, 9, 64'h0030_0000, 9, 64'h0038_0000, 9, 3, 0);
        run_walk(64'h0000_1111_2222_3333, 1, 1'b0, 1'b0, "R2 bad root width");
        // bad widths deeper in the tree (R2)
        setup(64'h0001_0000, 52, 13, 64'h0020_0000, 8, 64'h0030_0000, 9, 64'h0038_0000, 9, 3, 0);
        run_walk(64'h0004_4444_5555_6666, 1, 1'b0, 1'b0, "R2 bad level1 width");
        setup(64'h0001_0000, 52, 13, 64'h0020_0000, 9, 64'h0030_0000, 5, 64'h0038_0000, 9, 3, 0);
        run_walk(64'h0004_4444_5555_6666, 1, 1'b0, 1'b0, "R2 bad level2 width");
        setup(64'h0001_0000, 52, 13, 64'h0020_0000, 9, 64'h0030_0000, 9, 64'h0038_0000, 7, 3, 0);
        run_walk(64'h0004_4444_5555_6666, 1, 1'b0, 1'b0, "R2 bad level3 width");
        // directory at the last level: fails at level 4 (R2)
        setup(64'h0001_0000, 52, 13, 64'h0020_0000, 9, 64'h0030_0000, 9, 64'h0038_0000, 9, 0, 2);
        run_walk(64'h0007_7777_8888_9999, 1, 1'b0, 1'b0, "R2 too deep");
        // misaligned bases are realigned (R4)
        setup(64'h0001_1238, 52, 13, 64'h0020_0100, 9, 64'h0030_0F00, 9, 64'h0038_0300, 5, 3, 0);
        for (int i = 0; i < 3; i++)
            run_walk(64'h000F_0F0F_3C3C_A5A5 ^ 64'(i * 64'h0000_1001_0010_0100), 1, 1'b0, 1'b0, "R4 realign");
        // stray responses and start while busy (R9, R10)
        setup(64'h0001_0000, 52, 13, 64'h0020_0000, 9, 64'h0030_0000, 9, 64'h0038_0000, 9, 3, 0);
        run_walk(64'h0009_8765_4321_0FED, 2, 1'b1, 1'b0, "R9 stray response");
        run_walk(64'h0006_5432_1FED_CBA9, 3, 1'b0, 1'b1, "R10 start while busy");
        run_walk(64'h0001_2345_6789_ABCD, 1, 1'b1, 1'b1, "R9 stray and poke");

        all_done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule